// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block is a slave port through which an external host reaches the internal data and program memories over one 16-bit multiplexed address/data bus. The host frames every transfer with an active-low select, plus an active-high address-latch strobe and active-low read and write strobes. It first latches an address word, then issues any number of reads or writes, and the latched address steps forward on its own. A busy indication, `host_ack`, is high while the port is working on an access. The host starts a new access only while it is low.

Reads are pipelined. A read puts the word fetched by the *previous* read on the bus at once and starts the fetch for the current address. In the default mode the bus switches to the new word when the fetch completes. In the hold mode it keeps the old word until the read strobe ends. Program words are 24 bits wide and move as two 16-bit halves. A configuration bit, reachable by the host through a reserved data address and by the core through a direct port, selects the hold mode.

The internal side is a single-cycle synchronous request interface. A read request returns its data on `mem_rdata` one clock later. The host strobes are taken as already synchronous to `clk`.

Top module: `host_mem_port`

## Requirements
- R1: After reset `host_ack` is low, the bus is not driven, hold mode is off, and the word returned by the first read is 0x0000.
- R2: An address latch lasts while select is low and latch is high. The address is the bus value on the last clock of the latch. Bit 14 selects program space (1) or data space (0), and bits 13:0 give the word address. A latch also resets the half-word selector to the first half.
- R3: A write lasts while select and write are both low. `host_ack` rises one clock after it starts and stays high for at least two clocks. The data stored is the bus value on the last clock of the write. A data-space write issues one memory write of {8'h00, data} one clock after the write ends, and `host_ack` is low on the following clock.
- R4: A program word is written as two writes. The first carries bits 23:8 and issues no memory access. The second carries bits 7:0 on bus bits 7:0 and issues one 24-bit memory write.
- R5: The address steps by one, wrapping within 14 bits, after each data-space access and after the second half of a program-space access. The space bit is kept.
- R6: While select and read are both low, the bus is driven, and from the start of the read it carries the word captured by the previous read. It is never driven during a write or an address latch.
- R7: In default mode `host_ack` is high for exactly two clocks of a read. When it falls, the bus carries the word at the current address.
- R8: A program-space read in the first half fetches the 24-bit word and yields bits 23:8. The second half yields {8'h00, bits 7:0} of that word without any memory access.
- R9: In hold mode the bus keeps the previous word for the whole read. The newly captured word appears at the next read.
- R10: Data address 0x3FE7 is a configuration register, not memory. Bit 14 is the hold-mode enable. A host write sets it from data bit 14 without a memory write. A host read returns it in bit 14 with other bits zero. The core sets it through `core_cfg_we`/`core_cfg_sro`.
- R11: Each access issues at most one memory request, lasting one clock, and none is issued during an address latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_n | input | 1 | Host port select, active low |
| host_latch | input | 1 | Address-latch strobe, active high |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_din | input | 16 | Bus value seen from the host |
| host_dout | output | 16 | Value the port drives on the bus |
| host_doe | output | 1 | Bus output enable |
| host_ack | output | 1 | Port busy; host waits until low |
| core_cfg_we | input | 1 | Core write strobe for the hold-mode bit |
| core_cfg_sro | input | 1 | Hold-mode value written by the core |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_pgm | output | 1 | Request targets program memory |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 24 | Write data (data space uses bits 15:0) |
| mem_rdata | input | 24 | Read data, valid one clock after a read request |

## Verification
The bench builds the port with its default widths: a 14-bit address, a 16-bit bus and 24-bit program words. It backs the port with 64-entry memories indexed by the low address bits. This is enough to sweep runs of consecutive data words and program-word halves, and to reach the configuration register at 0x3FE7 as well as the wrap from 0x3FFF to 0. The bench keeps its own model of the address, the half selector, the previously captured word and the hold bit. Every bus value, memory write and request count is predicted from that model.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WACT,
    S_WCOMMIT,
    S_RFETCH,
    S_RCAP,
    S_RHOLD
  } hmp_state_t;

  // Next word address, wrapping inside a field of w bits.
  function automatic logic [31:0] wrap_inc(logic [31:0] v, int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v + 32'd1) & mask;
  endfunction

  // A single flag placed at bit position pos.
  function automatic logic [31:0] bit_at(logic b, int unsigned pos);
    return {31'd0, b} << pos;
  endfunction

endpackage

// File: rtl/hmp_strobe.sv
module hmp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic start,
  output logic stop
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  assign start = cond && !prev_q;
  assign stop  = !cond && prev_q;
endmodule

// File: rtl/hmp_addr.sv
module hmp_addr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_cond,
  input  logic          lat_start,
  input  logic          lat_stop,
  input  logic [AW-1:0] lat_addr,
  input  logic          lat_space,
  input  logic          step,
  input  logic          half_set,
  input  logic          half_clr,
  output logic [AW-1:0] addr_q,
  output logic          pgm_q,
  output logic          half_q
);
  logic [AW-1:0] cap_addr_q;
  logic          cap_space_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q  <= '0;
      cap_space_q <= 1'b0;
    end else if (lat_cond) begin
      cap_addr_q  <= lat_addr;
      cap_space_q <= lat_space;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pgm_q  <= 1'b0;
    end else if (lat_stop) begin
      addr_q <= cap_addr_q;
      pgm_q  <= cap_space_q;
    end else if (step) begin
      addr_q <= AW'(hmp_pkg::wrap_inc(32'(addr_q), AW));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         half_q <= 1'b0;
    else if (lat_start) half_q <= 1'b0;
    else if (half_clr)  half_q <= 1'b0;
    else if (half_set)  half_q <= 1'b1;
  end
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl #(
  parameter int DW = 16,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cond,
  input  logic          wr_cond,
  input  logic          rd_start,
  input  logic          rd_stop,
  input  logic          wr_start,
  input  logic          wr_stop,
  input  logic          pgm,
  input  logic          half,
  input  logic          is_ovl,
  input  logic [DW-1:0] ovl_word,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [PW-1:0] mem_wdata,
  output logic          step,
  output logic          half_set,
  output logic          half_clr,
  output logic          ovl_wr,
  output logic          ovl_bitval,
  output logic          cap_valid,
  output logic [DW-1:0] cap_val,
  output logic          rd_done
);
  import hmp_pkg::*;

  localparam int LOW_W   = PW - DW;
  localparam int OVL_POS = 14;

  hmp_state_t    st_q, st_d;
  logic [DW-1:0] wbuf_q;
  logic [DW-1:0] pm_hi_q;
  logic [LOW_W-1:0] pm_lo_q;

  assign busy       = (st_q == S_WACT) || (st_q == S_WCOMMIT) ||
                      (st_q == S_RFETCH) || (st_q == S_RCAP);
  assign ovl_bitval = wbuf_q[OVL_POS];

  always_comb begin
    st_d      = st_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    step      = 1'b0;
    half_set  = 1'b0;
    half_clr  = 1'b0;
    ovl_wr    = 1'b0;
    cap_valid = 1'b0;
    cap_val   = '0;
    rd_done   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (wr_start)      st_d = S_WACT;
        else if (rd_start) st_d = S_RFETCH;
      end
      S_WACT: begin
        if (wr_stop) st_d = S_WCOMMIT;
      end
      S_WCOMMIT: begin
        st_d = S_IDLE;
        if (!pgm) begin
          step = 1'b1;
          if (is_ovl) ovl_wr = 1'b1;
          else begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = PW'(wbuf_q);
          end
        end else if (!half) begin
          half_set = 1'b1;
        end else begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = {pm_hi_q, wbuf_q[LOW_W-1:0]};
          step      = 1'b1;
          half_clr  = 1'b1;
        end
      end
      S_RFETCH: begin
        st_d = S_RCAP;
        if (!(pgm && half) && !is_ovl) mem_req = 1'b1;
      end
      S_RCAP: begin
        cap_valid = 1'b1;
        st_d      = rd_cond ? S_RHOLD : S_IDLE;
        if (!pgm) begin
          step    = 1'b1;
          cap_val = is_ovl ? ovl_word : mem_rdata[DW-1:0];
        end else if (!half) begin
          cap_val  = mem_rdata[PW-1:LOW_W];
          half_set = 1'b1;
        end else begin
          cap_val  = DW'(pm_lo_q);
          step     = 1'b1;
          half_clr = 1'b1;
        end
      end
      S_RHOLD: begin
        if (rd_stop) begin
          st_d    = S_IDLE;
          rd_done = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      wbuf_q  <= '0;
      pm_hi_q <= '0;
      pm_lo_q <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == S_IDLE && wr_start) || (st_q == S_WACT && wr_cond))
        wbuf_q <= din;
      if (st_q == S_WCOMMIT && pgm && !half)
        pm_hi_q <= wbuf_q;
      if (st_q == S_RCAP && pgm && !half)
        pm_lo_q <= mem_rdata[LOW_W-1:0];
    end
  end
endmodule

// File: rtl/hmp_rdpath.sv
module hmp_rdpath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic [DW-1:0] cap_val,
  input  logic          defer,
  input  logic          rd_done,
  output logic [DW-1:0] rhold_q
);
  logic [DW-1:0] pend_q;
  logic          pend_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhold_q  <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (cap_valid) begin
      if (defer) begin
        pend_q   <= cap_val;
        pend_v_q <= 1'b1;
      end else begin
        rhold_q  <= cap_val;
      end
    end else if (rd_done && pend_v_q) begin
      rhold_q  <= pend_q;
      pend_v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
  parameter int          AW        = 14,
  parameter int          DW        = 16,
  parameter int          PW        = 24,
  parameter int          SPACE_BIT = 14,
  parameter int          SRO_BIT   = 14,
  parameter logic [13:0] OVL_ADDR  = 14'h3FE7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_n,
  input  logic          host_latch,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  output logic          host_ack,
  input  logic          core_cfg_we,
  input  logic          core_cfg_sro,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_pgm,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] mem_wdata,
  input  logic [PW-1:0] mem_rdata
);
  localparam int NSTB = 3;  // 0 read, 1 write, 2 address latch

  logic [NSTB-1:0] cond, ev_start, ev_stop;
  logic [AW-1:0]   addr_q;
  logic            pgm_q, half_q, is_ovl, sro_q;
  logic            step, half_set, half_clr, ovl_wr, ovl_bitval;
  logic            cap_valid, rd_done;
  logic [DW-1:0]   cap_val, rhold_q, ovl_word;
  logic            ev_mem_rd, ev_mem_wr;

  assign cond[0] = !host_sel_n && !host_rd_n;
  assign cond[1] = !host_sel_n && !host_wr_n;
  assign cond[2] = !host_sel_n && host_latch;

  genvar g;
  generate
    for (g = 0; g < NSTB; g++) begin : g_stb
      hmp_strobe u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond[g]),
        .start (ev_start[g]),
        .stop  (ev_stop[g])
      );
    end
  endgenerate

  hmp_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_cond  (cond[2]),
    .lat_start (ev_start[2]),
    .lat_stop  (ev_stop[2]),
    .lat_addr  (host_din[AW-1:0]),
    .lat_space (host_din[SPACE_BIT]),
    .step      (step),
    .half_set  (half_set),
    .half_clr  (half_clr),
    .addr_q    (addr_q),
    .pgm_q     (pgm_q),
    .half_q    (half_q)
  );

  assign is_ovl   = !pgm_q && (addr_q == AW'(OVL_ADDR));
  assign ovl_word = DW'(hmp_pkg::bit_at(sro_q, SRO_BIT));

  hmp_ctrl #(.DW(DW), .PW(PW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_cond    (cond[0]),
    .wr_cond    (cond[1]),
    .rd_start   (ev_start[0]),
    .rd_stop    (ev_stop[0]),
    .wr_start   (ev_start[1]),
    .wr_stop    (ev_stop[1]),
    .pgm        (pgm_q),
    .half       (half_q),
    .is_ovl     (is_ovl),
    .ovl_word   (ovl_word),
    .din        (host_din),
    .mem_rdata  (mem_rdata),
    .busy       (host_ack),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .step       (step),
    .half_set   (half_set),
    .half_clr   (half_clr),
    .ovl_wr     (ovl_wr),
    .ovl_bitval (ovl_bitval),
    .cap_valid  (cap_valid),
    .cap_val    (cap_val),
    .rd_done    (rd_done)
  );

  hmp_rdpath #(.DW(DW)) u_rdpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_valid (cap_valid),
    .cap_val   (cap_val),
    .defer     (sro_q && cond[0]),
    .rd_done   (rd_done),
    .rhold_q   (rhold_q)
  );

  // Hold-mode bit: a host write in the same clock overrides the core.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sro_q <= 1'b0;
    else if (ovl_wr)      sro_q <= ovl_bitval;
    else if (core_cfg_we) sro_q <= core_cfg_sro;
  end

  assign mem_pgm   = pgm_q;
  assign mem_addr  = addr_q;
  assign host_dout = rhold_q;
  assign host_doe  = cond[0];
  assign ev_mem_rd = mem_req && !mem_we;
  assign ev_mem_wr = mem_req && mem_we;
endmodule

// File: rtl/hmp_port_chk.sv
module hmp_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel_n,
  input logic          host_latch,
  input logic          host_wr_n,
  input logic [DW-1:0] host_dout,
  input logic          host_doe,
  input logic          host_ack,
  input logic          mem_req,
  input logic          ev_mem_rd,
  input logic          ev_mem_wr,
  input logic          sro_q
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !host_ack);

  p_ack_two_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |=> host_ack);

  p_write_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_wr |=> !host_ack);

  p_no_drive_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel_n && !host_wr_n) |-> !host_doe);

  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_rd |=> host_ack ##1 !host_ack);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sro_q && $past(sro_q) && host_doe && $past(host_doe)) |-> $stable(host_dout));

  p_single_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_no_req_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel_n && host_latch && !host_ack) |-> !mem_req);
endmodule

bind host_mem_port hmp_port_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel_n (host_sel_n),
  .host_latch (host_latch),
  .host_wr_n  (host_wr_n),
  .host_dout  (host_dout),
  .host_doe   (host_doe),
  .host_ack   (host_ack),
  .mem_req    (mem_req),
  .ev_mem_rd  (ev_mem_rd),
  .ev_mem_wr  (ev_mem_wr),
  .sro_q      (sro_q)
);

// File: tb/host_mem_port_bench.sv
module host_mem_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel_n = 1'b1, host_latch = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [15:0] host_din = 16'h0;
  logic [15:0] host_dout;
  logic        host_doe, host_ack;
  logic        core_cfg_we = 1'b0, core_cfg_sro = 1'b0;
  logic        mem_req, mem_we, mem_pgm;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = 24'h0;

  always #2 clk = ~clk;

  host_mem_port u_host_mem_port (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_latch(host_latch),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .host_ack(host_ack),
    .core_cfg_we(core_cfg_we), .core_cfg_sro(core_cfg_sro),
    .mem_req(mem_req), .mem_we(mem_we), .mem_pgm(mem_pgm), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Behavioural memories
  logic [15:0] dm [0:63];
  logic [23:0] pm [0:63];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [13:0] last_addr = 14'h0;
  logic [23:0] last_data = 24'h0;
  logic        last_pgm = 1'b0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        wr_cnt++;
        last_addr = mem_addr;
        last_data = mem_wdata;
        last_pgm  = mem_pgm;
        if (mem_pgm) pm[mem_addr[5:0]] = mem_wdata;
        else         dm[mem_addr[5:0]] = mem_wdata[15:0];
      end else begin
        rd_cnt++;
        mem_rdata <= mem_pgm ? pm[mem_addr[5:0]] : {8'h00, dm[mem_addr[5:0]]};
      end
    end
  end

  int errs = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench model of the port
  int          e_addr = 0;
  bit          e_pgm = 0, e_half = 0, e_sro = 0;
  logic [15:0] e_prev = 16'h0;
  logic [15:0] e_hi = 16'h0;

  function automatic int inc14(int a);
    return (a + 1) % 16384;
  endfunction

  task automatic latch_addr(input logic [15:0] a);
    int reqs;
    reqs = rd_cnt + wr_cnt;
    @(negedge clk); host_sel_n = 1'b0; host_latch = 1'b1; host_din = ~a;
    @(negedge clk); host_din = a;
    chk(host_doe == 1'b0, "R6", "bus driven during latch", 32'(host_doe), 0);
    @(negedge clk); host_latch = 1'b0; host_sel_n = 1'b1; host_din = 16'h0;
    @(negedge clk);
    chk(rd_cnt + wr_cnt == reqs, "R11", "request during latch", 32'(rd_cnt + wr_cnt), 32'(reqs));
    e_addr = int'(a[13:0]); e_pgm = a[14]; e_half = 0;
  endtask

  task automatic do_read(input string req);
    logic [15:0] nv;
    int          ackc, rc0, fetch;
    bit          ovl;
    ovl = !e_pgm && (e_addr == 16'h3FE7);
    if (!e_pgm) nv = ovl ? (e_sro ? 16'h4000 : 16'h0000) : dm[e_addr % 64];
    else if (!e_half) nv = pm[e_addr % 64][23:8];
    else nv = {8'h00, pm[e_addr % 64][7:0]};
    fetch = (ovl || (e_pgm && e_half)) ? 0 : 1;
    rc0 = rd_cnt;
    @(negedge clk); host_sel_n = 1'b0; host_rd_n = 1'b0;
    #1;
    chk(host_doe == 1'b1, "R6", "bus enable at read start", 32'(host_doe), 1);
    chk(host_dout == e_prev, "R6", "previous word at read start", 32'(host_dout), 32'(e_prev));
    ackc = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (host_ack) ackc++;
      else break;
    end
    chk(ackc == 2, "R7", "ack clocks during read", 32'(ackc), 2);
    chk(host_dout == (e_sro ? e_prev : nv), e_sro ? "R9" : req,
        "bus after fetch", 32'(host_dout), 32'(e_sro ? e_prev : nv));
    chk(rd_cnt - rc0 == fetch, "R8", "memory reads per access", 32'(rd_cnt - rc0), 32'(fetch));
    host_sel_n = 1'b1; host_rd_n = 1'b1;
    #1;
    chk(host_doe == 1'b0, "R6", "bus released after read", 32'(host_doe), 0);
    e_prev = nv;
    if (!e_pgm) e_addr = inc14(e_addr);
    else if (!e_half) e_half = 1;
    else begin e_half = 0; e_addr = inc14(e_addr); end
    @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] d_early, input logic [15:0] d);
    int  wc0, ackc;
    bit  ovl;
    ovl = !e_pgm && (e_addr == 16'h3FE7);
    wc0 = wr_cnt;
    @(negedge clk); host_sel_n = 1'b0; host_wr_n = 1'b0; host_din = d_early;
    @(negedge clk);
    chk(host_ack == 1'b1, "R3", "ack one clock after write start", 32'(host_ack), 1);
    host_din = d;
    @(negedge clk);
    chk(host_doe == 1'b0, "R6", "bus driven during write", 32'(host_doe), 0);
    host_sel_n = 1'b1; host_wr_n = 1'b1; host_din = 16'hDEAD;
    ackc = 2;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (host_ack) ackc++;
      else break;
    end
    chk(ackc == 3, "R3", "ack clocks for write", 32'(ackc), 3);
    if (!e_pgm) begin
      if (ovl) begin
        chk(wr_cnt == wc0, "R10", "memory write to config register", 32'(wr_cnt - wc0), 0);
        e_sro = d[14];
      end else begin
        chk(wr_cnt == wc0 + 1, "R3", "one data write", 32'(wr_cnt - wc0), 1);
        chk(last_addr == 14'(e_addr) && !last_pgm, "R5", "data write address",
            32'(last_addr), 32'(e_addr));
        chk(last_data == {8'h00, d}, "R3", "data sampled at write end", 32'(last_data), 32'({8'h00, d}));
      end
      e_addr = inc14(e_addr);
    end else if (!e_half) begin
      chk(wr_cnt == wc0, "R4", "no write on first half", 32'(wr_cnt - wc0), 0);
      e_hi = d; e_half = 1;
    end else begin
      chk(wr_cnt == wc0 + 1 && last_pgm, "R4", "program word write", 32'(wr_cnt - wc0), 1);
      chk(last_data == {e_hi, d[7:0]}, "R4", "program word value", 32'(last_data), 32'({e_hi, d[7:0]}));
      chk(last_addr == 14'(e_addr), "R5", "program write address", 32'(last_addr), 32'(e_addr));
      e_half = 0; e_addr = inc14(e_addr);
    end
  endtask

  task automatic core_set(input bit v);
    @(negedge clk); core_cfg_we = 1'b1; core_cfg_sro = v;
    @(negedge clk); core_cfg_we = 1'b0;
    e_sro = v;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      dm[i] = 16'hA000 + 16'(i * 37);
      pm[i] = 24'h3C0000 + 24'(i * 70001 + 5);
    end
    repeat (4) @(negedge clk);
    chk(host_ack == 1'b0, "R1", "ack in reset", 32'(host_ack), 0);
    chk(host_doe == 1'b0, "R1", "bus idle in reset", 32'(host_doe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ack == 1'b0, "R1", "ack after reset", 32'(host_ack), 0);

    // Data reads, including the first read after reset returning zero (R1)
    latch_addr(16'h0005);
    for (int i = 0; i < 16; i++) do_read("R7");
    chk(e_addr == 21, "R5", "model step count", 32'(e_addr), 21);

    // Data writes with the bus changing mid-write, then read back (R2, R3)
    latch_addr(16'h001E);
    for (int i = 0; i < 4; i++) do_write(16'h1111, 16'h5A00 + 16'(i * 7));
    latch_addr(16'h001E);
    for (int i = 0; i < 5; i++) do_read("R2");

    // Program words in halves (R4, R8)
    latch_addr(16'h4028);
    do_write(16'h0, 16'hBEEF); do_write(16'h0, 16'h0042);
    do_write(16'h0, 16'h1234); do_write(16'h0, 16'h00AB);
    latch_addr(16'h4028);
    for (int i = 0; i < 8; i++) do_read("R8");

    // Configuration register and hold mode (R10, R9)
    latch_addr(16'h3FE7);
    do_read("R10");
    latch_addr(16'h3FE7);
    do_write(16'h0000, 16'h4000);
    latch_addr(16'h3FE7);
    do_read("R10");
    latch_addr(16'h0008);
    for (int i = 0; i < 4; i++) do_read("R9");
    latch_addr(16'h4030);
    for (int i = 0; i < 4; i++) do_read("R9");
    core_set(1'b0);
    latch_addr(16'h3FE7);
    do_read("R10");
    do_read("R7");
    core_set(1'b1);
    latch_addr(16'h3FE7);
    do_read("R10");
    do_read("R10");
    latch_addr(16'h3FE7);
    do_write(16'h0000, 16'h0000);
    latch_addr(16'h000C);
    do_read("R10");
    do_read("R7");

    // Address wrap (R5)
    latch_addr(16'h3FFF);
    do_write(16'h0000, 16'h7777);
    chk(e_addr == 0, "R5", "model wrap", 32'(e_addr), 0);
    do_read("R5");
    do_read("R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule